// File: doc/BRIEF.md
# Interval Timer with Count Snapshot

This block is a down-counting interval timer reached through a small word-addressed register bus. Software programs a timeout period as two 16-bit halves, issues a start command, and the counter then steps down by one on every clock. When the counter leaves zero it raises a timeout flag and reloads the period. It then either keeps running, in continuous mode, or halts, in one-shot mode. An interrupt line follows the timeout flag when the interrupt enable is set.

The live count is never visible on the bus. Software writes any value to the snapshot-low slot, which freezes the current count in a 32-bit snapshot register, and then reads both halves at leisure without tearing. With a period of all ones, the bitwise inverse of the snapshot is the number of clocks that have elapsed since the start.

Register slots (word index on `busAddr`): 0 status, 1 control, 2 period low, 3 period high, 4 snapshot low, 5 snapshot high. Slots 6 and 7 are unused. Reads are combinational from `busAddr`. Writes take effect at the clock edge on which `busWrite` is high.

Top module: `interval_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the period, counter, snapshot, status and control state, so every slot reads 0 and `irq` is 0.
- R2: Writes to slot 2 and slot 3 store data bits [15:0] as the low and high period halves and ignore bits [31:16]. Reads of slots 2 and 3 return the stored half in bits [15:0] with bits [31:16] zero.
- R3: Writing control bit 2 (start) sets running. While running, the counter decreases by one each clock. Status bit 1 reads 1 while running.
- R4: Writing control bit 3 (stop) clears running on that edge, even when bit 2 is set in the same write. Control bits 2 and 3 always read back as 0.
- R5: Any write to slot 4 copies the counter value held before that edge into the snapshot. Slot 4 returns snapshot bits [15:0], slot 5 returns bits [31:16], and neither changes until the next slot 4 write.
- R6: On the clock after the running counter reaches 0, status bit 0 (timeout) sets and the counter reloads the period. In one-shot mode (control bit 1 = 0) running clears on that edge.
- R7: In continuous mode (control bit 1 = 1) running stays set across the reload. Control bits [1:0] read back as written.
- R8: A write to slot 0 clears the timeout flag, except on an edge where a new timeout occurs, which wins.
- R9: `irq` is 1 exactly when the timeout flag is set and control bit 0 (interrupt enable) is 1.
- R10: A write to either period half clears running. The next start then loads the counter with the full 32-bit period.
- R11: Writing 0 to status, then 0 to control, then control bit 3 leaves the timer idle, with status reading 0 from reset.
- R12: Writes to slots 6 and 7 change no state, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWrite | input | 1 | Write strobe for the addressed slot |
| busAddr | input | 3 | Word slot index |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for the addressed slot |
| irq | output | 1 | Timeout interrupt, gated by the enable bit |

## Verification
The counting path is exercised with a short period in one-shot and continuous modes, where the exact reload cycle shows up in the status word and the snapshot. It is also exercised with an all-ones period, where the snapshot's inverse gives the elapsed clocks and any off-by-one in the capture edge shows. Control writes combine start and stop to separate the stop priority from plain stop, and start-after-period-write tells a full reload from a resumed count. Period writes with junk upper bits, writes to unused slots, status clears and a mid-run reset show which state each write may touch.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int SLOT_STATUS  = 0;
  localparam int SLOT_CONTROL = 1;
  localparam int SLOT_PER_LO  = 2;
  localparam int SLOT_PER_HI  = 3;
  localparam int SLOT_SNAP_LO = 4;
  localparam int SLOT_SNAP_HI = 5;

  localparam int CTL_IRQ_EN = 0;
  localparam int CTL_CONT   = 1;
  localparam int CTL_START  = 2;
  localparam int CTL_STOP   = 3;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic loadPeriod;
    logic decrement;
    logic takeSnap;
    logic wrPeriodLo;
    logic wrPeriodHi;
  } tmrStrobes_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        ctlData,
  input  logic              counterZero,
  output tmrStrobes_t       strobes,
  output logic              running,
  output logic              timeoutFlag,
  output logic              irqEn,
  output logic              contMode,
  output logic              irq
);

  logic statusWr, controlWr, perLoWr, perHiWr, snapWr;
  logic startCmd, stopCmd, wrapEvent, reloadPending;

  assign statusWr  = busWrite && (busAddr == ADDR_W'(SLOT_STATUS));
  assign controlWr = busWrite && (busAddr == ADDR_W'(SLOT_CONTROL));
  assign perLoWr   = busWrite && (busAddr == ADDR_W'(SLOT_PER_LO));
  assign perHiWr   = busWrite && (busAddr == ADDR_W'(SLOT_PER_HI));
  assign snapWr    = busWrite && (busAddr == ADDR_W'(SLOT_SNAP_LO));

  assign stopCmd   = controlWr && ctlData[CTL_STOP];
  assign startCmd  = controlWr && ctlData[CTL_START] && !stopCmd;
  assign wrapEvent = running && counterZero;

  always_comb begin
    strobes            = '0;
    strobes.loadPeriod = wrapEvent || (startCmd && reloadPending);
    strobes.decrement  = running && !counterZero;
    strobes.takeSnap   = snapWr;
    strobes.wrPeriodLo = perLoWr;
    strobes.wrPeriodHi = perHiWr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else if (stopCmd || perLoWr || perHiWr) begin
      running <= 1'b0;
    end else if (startCmd) begin
      running <= 1'b1;
    end else if (wrapEvent && !contMode) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reloadPending <= 1'b0;
    end else if (perLoWr || perHiWr) begin
      reloadPending <= 1'b1;
    end else if (startCmd) begin
      reloadPending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timeoutFlag <= 1'b0;
    end else if (wrapEvent) begin
      timeoutFlag <= 1'b1;
    end else if (statusWr) begin
      timeoutFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqEn    <= 1'b0;
      contMode <= 1'b0;
    end else if (controlWr) begin
      irqEn    <= ctlData[CTL_IRQ_EN];
      contMode <= ctlData[CTL_CONT];
    end
  end

  assign irq = timeoutFlag & irqEn;

endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  tmrStrobes_t       strobes,
  input  logic [HALF_W-1:0] wrHalf,
  output logic [CNT_W-1:0]  counterVal,
  output logic [CNT_W-1:0]  periodVal,
  output logic [CNT_W-1:0]  snapVal,
  output logic              counterZero
);

  logic [1:0] halfWr;
  assign halfWr = {strobes.wrPeriodHi, strobes.wrPeriodLo};

  // one register per period half
  for (genvar h = 0; h < 2; h++) begin : g_period
    always_ff @(posedge clk) begin
      if (rst) begin
        periodVal[h*HALF_W +: HALF_W] <= '0;
      end else if (halfWr[h]) begin
        periodVal[h*HALF_W +: HALF_W] <= wrHalf;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      counterVal <= '0;
    end else if (strobes.loadPeriod) begin
      counterVal <= periodVal;
    end else if (strobes.decrement) begin
      counterVal <= counterVal - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snapVal <= '0;
    end else if (strobes.takeSnap) begin
      snapVal <= counterVal;
    end
  end

  assign counterZero = (counterVal == '0);

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              running,
  input  logic              timeoutFlag,
  input  logic              irqEn,
  input  logic              contMode,
  input  logic [CNT_W-1:0]  periodVal,
  input  logic [CNT_W-1:0]  snapVal,
  output logic [DATA_W-1:0] busRData
);

  logic [HALF_W-1:0] slotHalf;

  always_comb begin
    slotHalf = '0;
    case (busAddr)
      ADDR_W'(SLOT_STATUS):  slotHalf = HALF_W'({running, timeoutFlag});
      ADDR_W'(SLOT_CONTROL): slotHalf = HALF_W'({contMode, irqEn});
      ADDR_W'(SLOT_PER_LO):  slotHalf = periodVal[HALF_W-1:0];
      ADDR_W'(SLOT_PER_HI):  slotHalf = periodVal[CNT_W-1:HALF_W];
      ADDR_W'(SLOT_SNAP_LO): slotHalf = snapVal[HALF_W-1:0];
      ADDR_W'(SLOT_SNAP_HI): slotHalf = snapVal[CNT_W-1:HALF_W];
      default:               slotHalf = '0;
    endcase
  end

  assign busRData = DATA_W'(slotHalf);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWData,
  output logic [DATA_W-1:0] busRData,
  output logic              irq
);

  tmrStrobes_t       strobes;
  logic              running, timeoutFlag, irqEn, contMode, counterZero;
  logic [CNT_W-1:0]  counterVal, periodVal, snapVal;

  tmr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .busWrite(busWrite), .busAddr(busAddr),
    .ctlData(busWData[3:0]), .counterZero(counterZero), .strobes(strobes),
    .running(running), .timeoutFlag(timeoutFlag), .irqEn(irqEn),
    .contMode(contMode), .irq(irq)
  );

  tmr_dp #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wrHalf(busWData[HALF_W-1:0]),
    .counterVal(counterVal), .periodVal(periodVal), .snapVal(snapVal),
    .counterZero(counterZero)
  );

  tmr_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W)) u_rd (
    .busAddr(busAddr), .running(running), .timeoutFlag(timeoutFlag),
    .irqEn(irqEn), .contMode(contMode), .periodVal(periodVal),
    .snapVal(snapVal), .busRData(busRData)
  );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWData,
  input logic              irq,
  input logic              running,
  input logic              timeoutFlag,
  input logic              irqEn,
  input logic              contMode,
  input logic [CNT_W-1:0]  counterVal,
  input logic [CNT_W-1:0]  periodVal,
  input logic [CNT_W-1:0]  snapVal
);

  logic ctlWr, snapWr, perLoWr, perAnyWr;
  assign ctlWr    = busWrite && (busAddr == ADDR_W'(SLOT_CONTROL));
  assign snapWr   = busWrite && (busAddr == ADDR_W'(SLOT_SNAP_LO));
  assign perLoWr  = busWrite && (busAddr == ADDR_W'(SLOT_PER_LO));
  assign perAnyWr = perLoWr || (busWrite && (busAddr == ADDR_W'(SLOT_PER_HI)));

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (running && counterVal != '0) |=> counterVal == $past(counterVal) - CNT_W'(1)); // R3

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
    (ctlWr && busWData[CTL_STOP]) |=> !running); // R4

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    snapWr |=> snapVal == $past(counterVal)); // R5

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !snapWr |=> $stable(snapVal)); // R5

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (running && counterVal == '0) |=> (counterVal == $past(periodVal)) && timeoutFlag); // R6

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
    (running && counterVal == '0 && !contMode && !ctlWr && !perAnyWr) |=> !running); // R6

  AST_CONT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (running && counterVal == '0 && contMode && !ctlWr && !perAnyWr) |=> running); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (irqEn && timeoutFlag)); // R9

  AST_PERIOD_STOPS: assert property (@(posedge clk) disable iff (rst)
    perAnyWr |=> !running); // R10

  AST_UPPER_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (perLoWr && busWData[DATA_W-1:HALF_W] != '0)
      |=> periodVal[HALF_W-1:0] == $past(busWData[HALF_W-1:0])); // R2

endmodule

bind interval_timer tmr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W)) u_chk (.*);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  interval_timer u0 (
    .clk(clk), .rst(rst), .busWrite(busWrite), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .irq(irq)
  );

  // vector: op[72:71] (0 write, 1 read-check, 2 idle N), addr[70:68],
  // data[67:36], expected[35:4], requirement[3:0]
  localparam int NV = 50;
  localparam logic [72:0] VEC [NV] = '{
    {2'd0, 3'd1, 32'h0,        32'h0,      4'd11}, // R11 control 0
    {2'd0, 3'd0, 32'h0,        32'h0,      4'd11}, // R11 status 0
    {2'd0, 3'd1, 32'h8,        32'h0,      4'd11}, // R11 stop
    {2'd1, 3'd0, 32'h0,        32'h0,      4'd11}, // R11 idle status
    {2'd0, 3'd2, 32'h5,        32'h0,      4'd2},  // R2 period low
    {2'd0, 3'd3, 32'h0,        32'h0,      4'd2},  // R2 period high
    {2'd1, 3'd2, 32'h0,        32'h5,      4'd2},
    {2'd1, 3'd3, 32'h0,        32'h0,      4'd2},
    {2'd0, 3'd1, 32'h4,        32'h0,      4'd3},  // R3 start one-shot
    {2'd1, 3'd0, 32'h0,        32'h2,      4'd3},  // R3 running
    {2'd1, 3'd1, 32'h0,        32'h0,      4'd4},  // R4 cmd bits read 0
    {2'd0, 3'd4, 32'hDEAD,     32'h0,      4'd5},  // R5 snap at count 5
    {2'd1, 3'd4, 32'h0,        32'h5,      4'd5},
    {2'd1, 3'd5, 32'h0,        32'h0,      4'd5},
    {2'd2, 3'd0, 32'd2,        32'h0,      4'd3},  // R3 two steps
    {2'd0, 3'd4, 32'h0,        32'h0,      4'd3},
    {2'd1, 3'd4, 32'h0,        32'h2,      4'd3},
    {2'd2, 3'd0, 32'd3,        32'h0,      4'd6},  // R6 reach timeout
    {2'd1, 3'd0, 32'h0,        32'h1,      4'd6},  // R6 flag set, halted
    {2'd0, 3'd0, 32'h0,        32'h0,      4'd8},  // R8 clear
    {2'd1, 3'd0, 32'h0,        32'h0,      4'd8},
    {2'd0, 3'd1, 32'h7,        32'h0,      4'd7},  // R7 continuous start
    {2'd2, 3'd0, 32'd6,        32'h0,      4'd7},
    {2'd1, 3'd0, 32'h0,        32'h3,      4'd7},  // R7 still running
    {2'd1, 3'd1, 32'h0,        32'h3,      4'd7},
    {2'd0, 3'd4, 32'h0,        32'h0,      4'd7},
    {2'd1, 3'd4, 32'h0,        32'h5,      4'd7},  // R7 reloaded
    {2'd0, 3'd2, 32'hABCDFFFF, 32'h0,      4'd10}, // R10 period write
    {2'd1, 3'd0, 32'h0,        32'h1,      4'd10}, // R10 stopped
    {2'd0, 3'd3, 32'h1234FFFF, 32'h0,      4'd2},
    {2'd1, 3'd2, 32'h0,        32'hFFFF,   4'd2},  // R2 upper ignored
    {2'd1, 3'd3, 32'h0,        32'hFFFF,   4'd2},
    {2'd0, 3'd1, 32'h6,        32'h0,      4'd10}, // R10 full reload
    {2'd0, 3'd4, 32'h0,        32'h0,      4'd5},
    {2'd1, 3'd4, 32'h0,        32'hFFFF,   4'd5},
    {2'd1, 3'd5, 32'h0,        32'hFFFF,   4'd5},
    {2'd2, 3'd0, 32'd9,        32'h0,      4'd3},
    {2'd0, 3'd4, 32'h0,        32'h0,      4'd5},
    {2'd1, 3'd4, 32'h0,        32'hFFF5,   4'd5},  // R5 ten ticks
    {2'd1, 3'd5, 32'h0,        32'hFFFF,   4'd5},
    {2'd0, 3'd1, 32'hC,        32'h0,      4'd4},  // R4 start+stop
    {2'd1, 3'd0, 32'h0,        32'h1,      4'd4},
    {2'd1, 3'd1, 32'h0,        32'h0,      4'd4},
    {2'd2, 3'd0, 32'd3,        32'h0,      4'd4},
    {2'd0, 3'd4, 32'h0,        32'h0,      4'd4},
    {2'd1, 3'd4, 32'h0,        32'hFFF3,   4'd4},  // R4 frozen count
    {2'd0, 3'd6, 32'hFFFF,     32'h0,      4'd12}, // R12 unused slot
    {2'd1, 3'd6, 32'h0,        32'h0,      4'd12},
    {2'd1, 3'd7, 32'h0,        32'h0,      4'd12},
    {2'd1, 3'd2, 32'h0,        32'hFFFF,   4'd12}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end in the low clock phase
  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    busAddr = a; busWData = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busWData = '0;
  endtask

  task automatic rdCheck(input logic [2:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    #1;
    check(tag, busRData, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 6; s++) rdCheck(3'(s), 32'h0, "R1 slot after reset");
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [2:0]  a;
      logic [31:0] d, e;
      string       tag;
      op = VEC[i][72:71]; a = VEC[i][70:68]; d = VEC[i][67:36]; e = VEC[i][35:4];
      tag = $sformatf("R%0d vector %0d", VEC[i][3:0], i);
      case (op)
        2'd0: wrReg(a, d);
        2'd1: rdCheck(a, e, tag);
        default: idle(int'(d));
      endcase
    end

    // R9 interrupt gating
    wrReg(3'd0, 32'h0);
    wrReg(3'd3, 32'h0);
    wrReg(3'd2, 32'h2);
    wrReg(3'd1, 32'h7);
    idle(2);
    check("R9 irq before timeout", {31'h0, irq}, 32'h0);
    idle(1);
    check("R9 irq on timeout", {31'h0, irq}, 32'h1);
    wrReg(3'd1, 32'h6);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    rdCheck(3'd0, 32'h3, "R9 flag kept while masked");

    // R10 period write while running, then full reload on start
    wrReg(3'd2, 32'h3);
    rdCheck(3'd0, 32'h1, "R10 period write halts");
    wrReg(3'd1, 32'h4);
    wrReg(3'd4, 32'h0);
    rdCheck(3'd4, 32'h3, "R10 counter reloaded");

    // R1 reset in the middle of a run
    wrReg(3'd1, 32'h7);
    idle(2);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    for (int s = 0; s < 6; s++) rdCheck(3'(s), 32'h0, "R1 slot after mid-run reset");
    check("R1 irq after mid-run reset", {31'h0, irq}, 32'h0);
    idle(4);
    rdCheck(3'd0, 32'h0, "R1 stays idle after reset");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule